// File: doc/BRIEF.md
# Recirculating Bidirectional-Pin Shift Register

This block is a register of configurable width (16 bits by default) that takes its state changes on the falling edge of its clock. Four operations are chosen from three control inputs: hold, serial load, serial read-out with recirculation, and parallel capture. A single serial pin is used in both directions. The chip boundary is expected to hold the real tri-state pad, so the block exposes that pin as three signals: a pad input value, a drive value and a drive enable.

When a frame is read serially, each bit that leaves the top position is fed back into the bottom position. A read of exactly WIDTH clocks therefore sends out the whole word, most significant bit first, and leaves the register with the value it had at the start. The parallel path loads a whole word in one clock. The serial path fills the register one bit per clock, starting at the bottom.

A monitor checks one timing rule: chip select must not be released while the clock is high. When that happens it raises a one-cycle flag. The whole register is also brought out on a read-only observation port.

Top module: `bidir_recirc_shreg`

## Requirements
- R1: While `cs_n` is 1 at a falling clock edge, the register keeps its value, and `sio_oe` is 0 for as long as `cs_n` is 1.
- R2: With `cs_n`=0 and `rw`=0, every falling edge shifts the register one place toward the top, and `sio_in` enters bit 0. This happens whatever the value of `mode`, and `sio_oe` stays 0.
- R3: With `cs_n`=0, `rw`=1 and `mode`=0, every falling edge shifts the register one place toward the top, and the old top bit enters bit 0.
- R4: With `cs_n`=0, `rw`=1 and `mode`=1, a falling edge copies `par_in` into the register without shifting.
- R5: `sio_oe` is 1 exactly when `cs_n`=0 and `rw`=1, outside reset. While `sio_oe` is 1, `sio_out` equals the top register bit. While `sio_oe` is 0, `sio_out` is 0.
- R6: A run of WIDTH recirculating clocks shows the starting word on `sio_out`, most significant bit first, one bit per clock before each shift. After the last clock the register holds its starting value again.
- R7: `glitch_err` is 1 for one clock period, from one falling edge to the next, after `cs_n` rises while `clk` is high. A release of `cs_n` while `clk` is low leaves it at 0.
- R8: Driving `rst_n` low clears the register and drops `sio_oe` at once, without waiting for a clock edge. After `rst_n` rises, the block stays in reset until the second falling edge. The first falling edge after that one performs an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 0 selects serial load, 1 selects the output-side operations |
| mode | input | 1 | When `rw`=1: 0 recirculates, 1 captures the parallel word |
| par_in | input | WIDTH | Parallel data word |
| sio_in | input | 1 | Value read from the shared serial pad |
| sio_out | output | 1 | Value driven onto the shared serial pad |
| sio_oe | output | 1 | Pad drive enable; 0 means high impedance |
| glitch_err | output | 1 | Flag for a chip-select release while the clock is high |
| dbg_q | output | WIDTH | Read-only view of the register contents |

## Verification
A wrong shift direction or a broken feedback path shows on `dbg_q` after the first falling edge. On `sio_out` it appears within one clock for the top bit, and a bit in the middle reaches the pin within WIDTH clocks. If recirculation loses a bit, the starting value is not restored after WIDTH read clocks, so a full read-out is compared with the starting word. A wrong enable decode shows at once on `sio_oe`, before any clock edge. A bad glitch monitor shows on `glitch_err` one falling edge after the release it should or should not have flagged.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  // Operation selected for the next falling clock edge.
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_SLOAD  = 2'd1,
    OP_RECIRC = 2'd2,
    OP_PLOAD  = 2'd3
  } shreg_op_e;

endpackage

// File: rtl/shreg_rst_sync.sv
module shreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stage_d = 1'b1;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  // Assertion is asynchronous, release follows the falling clock edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/shreg_decode.sv
module shreg_decode
  import shreg_pkg::*;
(
  input  logic      rst_ok,
  input  logic      cs_n,
  input  logic      rw,
  input  logic      mode,
  output shreg_op_e op,
  output logic      drive_en
);

  always_comb begin
    if (!rst_ok || cs_n) op = OP_HOLD;
    else if (!rw)        op = OP_SLOAD;
    else if (!mode)      op = OP_RECIRC;
    else                 op = OP_PLOAD;
  end

  assign drive_en = rst_ok & ~cs_n & rw;

endmodule

// File: rtl/shreg_core.sv
module shreg_core
  import shreg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shreg_op_e        op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;

  always_comb begin
    upd_en = (op != OP_HOLD);
    unique case (op)
      OP_SLOAD:  q_nxt = {q_r[TOP-1:0], ser_in};
      OP_RECIRC: q_nxt = {q_r[TOP-1:0], q_r[TOP]};
      OP_PLOAD:  q_nxt = par_in;
      default:   q_nxt = q_r;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (upd_en) q_r <= q_nxt;
  end

  assign q = q_r;

endmodule

// File: rtl/shreg_cs_monitor.sv
module shreg_cs_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic viol
);

  // Chip select level seen at the last rising edge.
  logic cs_hi_q;
  logic viol_q;
  logic viol_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_hi_q <= 1'b1;
    else        cs_hi_q <= cs_n;
  end

  // Low at the rising edge, high at the falling edge: released while clk high.
  always_comb viol_d = cs_n & ~cs_hi_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign viol = viol_q;

endmodule

// File: rtl/bidir_recirc_shreg.sv
module bidir_recirc_shreg
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             sio_in,
  output logic             sio_out,
  output logic             sio_oe,
  output logic             glitch_err,
  output logic [WIDTH-1:0] dbg_q
);

  localparam int TOP = WIDTH - 1;

  logic             rst_sync_n;
  shreg_op_e        op;
  logic             drive_en;
  logic [WIDTH-1:0] q;

  shreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  shreg_decode u_dec (
    .rst_ok   (rst_sync_n),
    .cs_n     (cs_n),
    .rw       (rw),
    .mode     (mode),
    .op       (op),
    .drive_en (drive_en)
  );

  shreg_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .ser_in (sio_in),
    .par_in (par_in),
    .q      (q)
  );

  shreg_cs_monitor u_mon (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cs_n  (cs_n),
    .viol  (glitch_err)
  );

  assign sio_oe  = drive_en;
  assign sio_out = drive_en & q[TOP];
  assign dbg_q   = q;

endmodule

// File: rtl/shreg_checker.sv
module shreg_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             cs_n,
  input logic             rw,
  input logic             mode,
  input logic [WIDTH-1:0] par_in,
  input logic             sio_in,
  input logic             sio_out,
  input logic             sio_oe,
  input logic [WIDTH-1:0] dbg_q
);

  p_hold_r1: assert property (@(negedge clk) disable iff (!rst_q_n)
    cs_n |=> $stable(dbg_q));

  p_hiz_r1: assert property (@(negedge clk) disable iff (!rst_q_n)
    cs_n |-> !sio_oe);

  p_sload_r2: assert property (@(negedge clk) disable iff (!rst_q_n)
    (!cs_n && !rw) |=> (dbg_q == {$past(dbg_q[WIDTH-2:0]), $past(sio_in)}));

  p_sload_in_r2: assert property (@(negedge clk) disable iff (!rst_q_n)
    (!cs_n && !rw) |-> !sio_oe);

  p_recirc_r3: assert property (@(negedge clk) disable iff (!rst_q_n)
    (!cs_n && rw && !mode) |=> (dbg_q == {$past(dbg_q[WIDTH-2:0]), $past(dbg_q[WIDTH-1])}));

  p_pload_r4: assert property (@(negedge clk) disable iff (!rst_q_n)
    (!cs_n && rw && mode) |=> (dbg_q == $past(par_in)));

  p_pin_r5: assert property (@(negedge clk) disable iff (!rst_q_n)
    sio_oe |-> (sio_out == dbg_q[WIDTH-1]));

  p_quiet_r5: assert property (@(negedge clk) disable iff (!rst_q_n)
    !sio_oe |-> !sio_out);

endmodule

bind bidir_recirc_shreg shreg_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_sync_n),
  .cs_n    (cs_n),
  .rw      (rw),
  .mode    (mode),
  .par_in  (par_in),
  .sio_in  (sio_in),
  .sio_out (sio_out),
  .sio_oe  (sio_oe),
  .dbg_q   (dbg_q)
);

// File: tb/tb_bidir_recirc_shreg.sv
module tb_bidir_recirc_shreg;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, rw, mode, sio_in;
  logic [W-1:0] par_in;
  logic         sio_out, sio_oe, glitch_err;
  logic [W-1:0] dbg_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] model_q;
  logic         prev_cs_n;

  typedef struct {
    logic [W-1:0] q;
    logic         oe;
    logic         out;
    logic         glit;
    string        req;
  } exp_t;

  exp_t sb[$];

  bidir_recirc_shreg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .mode(mode),
    .par_in(par_in), .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe),
    .glitch_err(glitch_err), .dbg_q(dbg_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: one expected item per rising edge, pushed by the driver.
  exp_t got;
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      got = sb.pop_front();
      chk(got.req, "register", dbg_q, got.q);
      chk(got.req, "drive enable", {15'd0, sio_oe}, {15'd0, got.oe});
      chk(got.req, "pin value", {15'd0, sio_out}, {15'd0, got.out});
      chk(got.req, "glitch flag", {15'd0, glitch_err}, {15'd0, got.glit});
    end
  end

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] q, input logic c,
      input logic r, input logic m, input logic [W-1:0] p, input logic s);
    if (c)       return q;
    else if (!r) return {q[W-2:0], s};
    else if (!m) return {q[W-2:0], q[W-1]};
    else         return p;
  endfunction

  // Driver: apply one operation after a rising edge, queue its outcome.
  task automatic drive_op(input logic c, input logic r, input logic m,
                          input logic [W-1:0] p, input logic s, input string req);
    exp_t e;
    @(posedge clk); #1;
    cs_n = c; rw = r; mode = m; par_in = p; sio_in = s;
    e.glit    = !prev_cs_n && c;
    prev_cs_n = c;
    model_q   = apply_op(model_q, c, r, m, p, s);
    e.q   = model_q;
    e.oe  = !c && r;
    e.out = e.oe & model_q[W-1];
    e.req = req;
    sb.push_back(e);
  endtask

  // Legal release: inputs stay for one more falling edge, then cs_n rises with clk low.
  task automatic release_cs(input string req);
    exp_t e;
    @(posedge clk); #1;
    model_q = apply_op(model_q, cs_n, rw, mode, par_in, sio_in);
    @(negedge clk); #1;
    cs_n      = 1'b1;
    prev_cs_n = 1'b1;
    e.q = model_q; e.oe = 1'b0; e.out = 1'b0; e.glit = 1'b0; e.req = req;
    sb.push_back(e);
  endtask

  initial begin
    logic [W-1:0] start;
    rst_n = 1'b0; cs_n = 1'b0; rw = 1'b1; mode = 1'b1; par_in = 16'hFFFF; sio_in = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R8", "register in reset", dbg_q, 16'h0000);
    chk("R8", "enable in reset", {15'd0, sio_oe}, 16'h0000);
    chk("R8", "pin in reset", {15'd0, sio_out}, 16'h0000);
    rst_n = 1'b1;
    @(posedge clk);
    chk("R8", "register after first release edge", dbg_q, 16'h0000);
    chk("R8", "enable after first release edge", {15'd0, sio_oe}, 16'h0000);
    @(posedge clk);
    chk("R8", "register after second release edge", dbg_q, 16'h0000);
    chk("R8", "enable after second release edge", {15'd0, sio_oe}, 16'h0001);
    @(posedge clk);
    chk("R8", "first operating edge", dbg_q, 16'hFFFF);
    model_q   = 16'hFFFF;
    prev_cs_n = 1'b0;

    // Parallel capture, two patterns.
    drive_op(0, 1, 1, 16'h3C5A, 0, "R4");
    drive_op(0, 1, 1, 16'hA5C3, 1, "R4");

    // Legal release, then hold under varied inputs.
    release_cs("R7");
    drive_op(1, 1, 1, 16'h0F0F, 1, "R1");
    drive_op(1, 0, 0, 16'hFFFF, 1, "R1");
    drive_op(1, 1, 0, 16'h0000, 0, "R1");

    // Serial load with mode toggling.
    for (int i = 0; i < 8; i++)
      drive_op(0, 0, logic'(i[0]), 16'hFFFF, logic'(i[1] ^ i[0]), "R2");

    // Full recirculating read: stream MSB first, value restored.
    start = model_q;
    for (int i = 0; i < W; i++) begin
      drive_op(0, 1, 0, 16'h0000, 0, "R3");
      #1;
      chk("R6", "emitted bit", {15'd0, sio_out}, {15'd0, start[W-1-i]});
    end
    @(posedge clk); #1;
    chk("R6", "value after full read", dbg_q, start);

    // Wrap boundary: top bit feeds bit 0.
    drive_op(0, 1, 1, 16'h8001, 0, "R4");
    drive_op(0, 1, 0, 16'h0000, 0, "R3");

    // Illegal release while clk high, then quiet cycle.
    drive_op(0, 1, 1, 16'h1234, 0, "R4");
    drive_op(1, 0, 0, 16'hFFFF, 1, "R7");
    drive_op(1, 1, 1, 16'h0000, 0, "R7");
    drive_op(0, 0, 1, 16'h0000, 1, "R2");
    drive_op(0, 1, 0, 16'h0000, 0, "R5");

    // Asynchronous reset mid-cycle.
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1;
    chk("R8", "async clear register", dbg_q, 16'h0000);
    chk("R8", "async clear enable", {15'd0, sio_oe}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule